// File: doc/BRIEF.md
# Program Memory Table Pointer Unit

This block moves single bytes between a byte-addressed program memory and an 8-bit holding latch. A 21-bit pointer selects the byte. A command either reads the addressed byte into the latch or writes the latch out to that address. Each command uses one of four pointer modes: unchanged, increment after the access, decrement after the access, or increment before the access. Software loads the pointer one byte lane at a time. It can also load the latch directly, so that a write has data to send.

The memory side uses a simple request/ready handshake. While a command is outstanding, `mem_req` stays high and the address, direction and write data stay stable. The unit waits until `mem_ready` is sampled high. In that same clock edge it captures read data and applies the pointer update, so the next command starts from the new pointer value. Only one command is in flight at a time, and `busy` reports it.

Top module: `prog_table_ptr`

## Requirements
- R1: After reset, `ptr` is 0, `latch` is 0, and `busy`, `mem_req` and `mem_we` are low.
- R2: When `cmd_valid` is high while `busy` is low, the command is accepted at that clock edge. From the next cycle `busy` and `mem_req` are high and `mem_we` equals the sampled `cmd_write` (1 = write). They stay high until the edge at which `mem_ready` is sampled high, and are low after it.
- R3: Mode code 0 (plain) addresses `ptr`. A read in this mode loads `mem_rdata` into `latch` at the completing edge and leaves `ptr` unchanged.
- R4: Mode code 1 (post-increment) addresses `ptr` and then sets `ptr` to `ptr+1` modulo 2^21.
- R5: Mode code 2 (post-decrement) addresses `ptr` and then sets `ptr` to `ptr-1` modulo 2^21, so 0 becomes 0x1FFFFF.
- R6: Mode code 3 (pre-increment) addresses `ptr+1` modulo 2^21, and `ptr` takes that value at completion. From 0x1FFFFF the access goes to address 0.
- R7: A write command drives `mem_wdata` with `latch` and leaves `latch` unchanged. Its pointer modes behave as for reads.
- R8: A command presented while `busy` is high is ignored. While a transfer waits for `mem_ready`, `mem_addr` and `ptr` hold.
- R9: With `ptr_wr_en` high, `ptr_wr_sel` 0 loads bits 7:0, 1 loads bits 15:8, and 2 loads bits 20:16 from `ptr_wr_data[4:0]`. Sel 3 has no effect. The load is ignored while `busy` or `cmd_valid` is high.
- R10: `latch_wr_en` loads `latch_wr_data` into `latch`, except while `busy` or `cmd_valid` is high.
- R11: A command accepted in the cycle right after a completion addresses the pointer value produced by that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write latch to memory, 0 = read into latch |
| cmd_mode | input | 2 | Pointer mode: 0 plain, 1 post-inc, 2 post-dec, 3 pre-inc |
| busy | output | 1 | Command outstanding |
| ptr_wr_en | input | 1 | Pointer byte-lane load |
| ptr_wr_sel | input | 2 | Byte lane to load |
| ptr_wr_data | input | 8 | Byte-lane data |
| latch_wr_en | input | 1 | Latch load |
| latch_wr_data | input | 8 | Latch load data |
| ptr | output | 21 | Current pointer |
| latch | output | 8 | Current latch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 21 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access completes at this edge |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |

## Verification
A command sampled at edge k shows up as `busy`, `mem_req`, address and direction from edge k+1. The pointer and latch results appear right after the edge at which `mem_ready` is sampled high, and `busy` falls at that same edge. Inputs change only on falling edges, and a behavioural model advances on each rising edge. Every output is compared with the model at the following falling edge, so each result is checked in the first cycle it is due and in every cycle it must hold. Directed checks after each command confirm exact pointer values at the wrap boundaries, the pre-increment address, and the cases where loads and commands are ignored.

// File: rtl/prog_table_ptr.sv
module prog_table_ptr #(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  input  logic              ptr_wr_en,
  input  logic [1:0]        ptr_wr_sel,
  input  logic [DATA_W-1:0] ptr_wr_data,
  input  logic              latch_wr_en,
  input  logic [DATA_W-1:0] latch_wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] latch,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [1:0] M_PLAIN   = 2'd0;
  localparam logic [1:0] M_POSTINC = 2'd1;
  localparam logic [1:0] M_POSTDEC = 2'd2;
  localparam logic [1:0] M_PREINC  = 2'd3;
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic              busy_q, we_q;
  logic [1:0]        mode_q;
  logic [PTR_W-1:0]  ptr_q, ptr_inc, ptr_dec;
  logic [DATA_W-1:0] latch_q;
  logic              accept, done, idle_wr;

  assign ptr_inc = ptr_q + ONE;
  assign ptr_dec = ptr_q - ONE;
  assign accept  = cmd_valid & ~busy_q;
  assign done    = busy_q & mem_ready;
  assign idle_wr = ~busy_q & ~cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      mode_q  <= M_PLAIN;
      ptr_q   <= '0;
      latch_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        we_q   <= cmd_write;
        mode_q <= cmd_mode;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (done) begin
        case (mode_q)
          M_POSTINC, M_PREINC: ptr_q <= ptr_inc;
          M_POSTDEC:           ptr_q <= ptr_dec;
          default:             ptr_q <= ptr_q;
        endcase
        if (!we_q) latch_q <= mem_rdata;
      end
      if (idle_wr && latch_wr_en) latch_q <= latch_wr_data;
      if (idle_wr && ptr_wr_en) begin
        for (int i = 0; i < PTR_W; i++)
          if (i / DATA_W == int'(ptr_wr_sel)) ptr_q[i] <= ptr_wr_data[i % DATA_W];
      end
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_we    = busy_q & we_q;
  assign mem_addr  = (mode_q == M_PREINC) ? ptr_inc : ptr_q;
  assign mem_wdata = latch_q;
  assign ptr       = ptr_q;
  assign latch     = latch_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> (busy && mem_req && mem_we == $past(cmd_write))); // R2
  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> (busy && $stable(ptr) && $stable(mem_addr))); // R8
  AST_PLAIN_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_PLAIN) |=> $stable(ptr)); // R3
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_we) |=> (latch == $past(mem_rdata))); // R3
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_POSTINC) |=> (ptr == PTR_W'($past(ptr) + 1))); // R4
  AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_POSTDEC) |=> (ptr == PTR_W'($past(ptr) - 1))); // R5
  AST_PREINC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == M_PREINC) |=> (ptr == $past(mem_addr))); // R6
  AST_WRITE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_we) |=> $stable(latch)); // R7
endmodule

// File: tb/sim_prog_table_ptr.sv
module sim_prog_table_ptr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, ptr_wr_en = 0, latch_wr_en = 0, mem_ready = 0;
  logic [1:0] cmd_mode = 0, ptr_wr_sel = 0;
  logic [7:0] ptr_wr_data = 0, latch_wr_data = 0, mem_wdata, mem_rdata, latch;
  logic busy, mem_req, mem_we;
  logic [20:0] ptr, mem_addr;
  int total = 0, bad = 0, cycles = 0, wait_cyc = 0, cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prog_table_ptr u0 (.clk, .rst_n, .cmd_valid, .cmd_write, .cmd_mode, .busy,
    .ptr_wr_en, .ptr_wr_sel, .ptr_wr_data, .latch_wr_en, .latch_wr_data,
    .ptr, .latch, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata);

  function automatic logic [7:0] rd_fn(logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_ptr = 0, m_latch = 0, m_mode = 0;
  bit m_busy = 0, m_we = 0;
  function automatic int m_addr();
    return (m_mode == 3) ? ((m_ptr + 1) & 21'h1FFFFF) : m_ptr;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_latch = 0; m_busy = 0; m_we = 0; m_mode = 0;
    end else if (m_busy) begin
      if (mem_ready) begin
        if (!m_we) m_latch = rd_fn(21'(m_addr()));
        if (m_mode == 1 || m_mode == 3) m_ptr = (m_ptr + 1) & 21'h1FFFFF;
        else if (m_mode == 2) m_ptr = (m_ptr - 1) & 21'h1FFFFF;
        m_busy = 0;
      end
    end else if (cmd_valid) begin
      m_busy = 1; m_we = cmd_write; m_mode = cmd_mode;
    end else begin
      if (latch_wr_en) m_latch = latch_wr_data;
      if (ptr_wr_en) case (ptr_wr_sel)
        2'd0: m_ptr = (m_ptr & 21'h1FFF00) | ptr_wr_data;
        2'd1: m_ptr = (m_ptr & 21'h1F00FF) | (int'(ptr_wr_data) << 8);
        2'd2: m_ptr = (m_ptr & 21'h00FFFF) | (int'(ptr_wr_data[4:0]) << 16);
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      if (rst_n) begin
        chk("R2 busy", busy, m_busy);
        chk("R2 mem_req", mem_req, m_busy);
        chk("R11 ptr", ptr, m_ptr);
        chk("R10 latch", latch, m_latch);
        if (m_busy) begin
          chk("R7 mem_we", mem_we, m_we);
          chk("R4 mem_addr", mem_addr, m_addr());
          if (m_we) chk("R7 mem_wdata", mem_wdata, m_latch);
        end
      end
      if (cycles > 50000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (!mem_req) begin mem_ready <= 0; cnt <= 0; end
    else if (cnt >= wait_cyc) mem_ready <= 1;
    else begin cnt <= cnt + 1; mem_ready <= 0; end
  end

  // tasks start and end at a falling edge
  task automatic issue(bit w, bit [1:0] m, int wt);
    wait_cyc = wt; cmd_valid = 1; cmd_write = w; cmd_mode = m;
    @(negedge clk); cmd_valid = 0;
    while (busy) @(negedge clk);
  endtask
  task automatic pwr(bit [1:0] s, bit [7:0] d);
    ptr_wr_en = 1; ptr_wr_sel = s; ptr_wr_data = d;
    @(negedge clk); ptr_wr_en = 0;
  endtask
  task automatic lwr(bit [7:0] d);
    latch_wr_en = 1; latch_wr_data = d;
    @(negedge clk); latch_wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ptr", ptr, 0); chk("R1 latch", latch, 0);
    chk("R1 busy", busy, 0); chk("R1 mem_req", mem_req, 0); chk("R1 mem_we", mem_we, 0);
    rst_n = 1;
    @(negedge clk);
    pwr(0, 8'hDE); pwr(1, 8'hBC); pwr(2, 8'hFA);
    chk("R9 lanes", ptr, 21'h1ABCDE);
    pwr(3, 8'h77);
    chk("R9 sel3", ptr, 21'h1ABCDE);
    issue(0, 0, 2);
    chk("R3 ptr", ptr, 21'h1ABCDE); chk("R3 latch", latch, rd_fn(21'h1ABCDE));
    issue(0, 1, 1);
    chk("R4 ptr", ptr, 21'h1ABCDF);
    issue(0, 2, 0);
    chk("R5 ptr", ptr, 21'h1ABCDE);
    issue(0, 3, 3);
    chk("R6 ptr", ptr, 21'h1ABCDF); chk("R6 latch", latch, rd_fn(21'h1ABCDF));
    pwr(0, 0); pwr(1, 0); pwr(2, 0);
    issue(0, 2, 1);
    chk("R5 wrap", ptr, 21'h1FFFFF);
    issue(0, 3, 0);
    chk("R6 wrap ptr", ptr, 0); chk("R6 wrap latch", latch, rd_fn(0));
    lwr(8'hA5);
    chk("R10 load", latch, 8'hA5);
    issue(1, 1, 2);
    chk("R7 latch kept", latch, 8'hA5); chk("R7 ptr", ptr, 1);
    // latch and pointer loads alongside cmd_valid are ignored
    latch_wr_en = 1; latch_wr_data = 8'h11; ptr_wr_en = 1; ptr_wr_sel = 0; ptr_wr_data = 8'h40;
    issue(1, 0, 1);
    latch_wr_en = 0; ptr_wr_en = 0;
    chk("R10 ignored", latch, 8'hA5); chk("R9 ignored", ptr, 1);
    // command and pointer load while busy are ignored
    wait_cyc = 4; cmd_valid = 1; cmd_write = 0; cmd_mode = 1;
    @(negedge clk); cmd_mode = 2; ptr_wr_en = 1; ptr_wr_sel = 1; ptr_wr_data = 8'h55;
    @(negedge clk); cmd_valid = 0; ptr_wr_en = 0;
    while (busy) @(negedge clk);
    chk("R8 ptr", ptr, 2); chk("R8 busy", busy, 0);
    // back-to-back: second command starts at once from the updated pointer
    wait_cyc = 0; cmd_valid = 1; cmd_write = 0; cmd_mode = 1;
    @(negedge clk); cmd_valid = 0;
    while (busy) @(negedge clk);
    cmd_valid = 1; cmd_mode = 0;
    @(negedge clk); cmd_valid = 0;
    chk("R11 addr", mem_addr, 3);
    while (busy) @(negedge clk);
    chk("R11 latch", latch, rd_fn(3));
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 3) == 0) lwr(8'($urandom));
      if ($urandom_range(0, 4) == 0) pwr(2'($urandom), 8'($urandom));
      issue(1'($urandom), 2'($urandom), $urandom_range(0, 3));
    end
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule